// File: doc/BRIEF.md
# Link Peek Memory Reader

This block copies a fixed window of memory out of a neighbour processor that has not been booted yet. The neighbour answers only a minimal peek protocol on a byte-wide link. For each peek, the reader sends a one-byte command and then an address. The neighbour replies with one word of data.

A single start pulse launches a run. The pulse also carries a word-size choice of 2 or 4 bytes per word, which sets the width of every address and reply word in that run. The reader begins at the most negative address for the chosen width and steps upward one word per peek. It gathers the returned bytes in a 60-byte staging buffer.

Each time the buffer fills, the reader sends it upstream as one length byte followed by the 60 data bytes. Ten such packets make up a run of 600 bytes. A lone zero byte then closes the run. All three byte streams (link out, link in and upstream) use valid/ready handshakes.

Top module: `link_peek_reader`

## Requirements
- R1: A one-cycle `start_i` while idle begins a run. `busy_o` is high from the clock edge that accepts the start until the edge that accepts the terminator byte.
- R2: Every peek transaction sends byte 0x01 on the link output. It then sends the address as word-size bytes, least significant byte first, and then accepts word-size reply bytes on the link input.
- R3: `word4_i` sampled with the start sets the word size for the run: 1 selects 4 bytes per word, 0 selects 2 bytes per word.
- R4: The first address of a run has 0x80 in its most significant byte and zeros below it: 0x8000 for 2-byte words and 0x80000000 for 4-byte words.
- R5: Each following transaction uses the previous address plus the word size. Address arithmetic wraps within the word size.
- R6: Reply bytes are forwarded upstream in exactly the order they arrived on the link input.
- R7: Upstream output is a series of packets. Each packet is a length byte of 60 followed by 60 data bytes. There are ten packets per run, 600 data bytes in total.
- R8: After the tenth packet a single 0x00 byte is sent upstream. Once it is accepted, `busy_o` falls on the next edge.
- R9: `start_i` pulses during a run are ignored. They change neither the word size, the address sequence nor the upstream stream.
- R10: On the link output and the upstream output, an asserted valid stays high with unchanged data until it is accepted.
- R11: After reset, `busy_o`, `link_tx_valid_o`, `link_rx_ready_o` and `up_valid_o` are all low.
- R12: At most one of `link_tx_valid_o`, `link_rx_ready_o` and `up_valid_o` is high in any cycle, and none is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a run |
| word4_i | input | 1 | Word size with start: 1 = 4 bytes, 0 = 2 bytes |
| busy_o | output | 1 | Run in progress |
| link_tx_data_o | output | 8 | Byte toward the neighbour |
| link_tx_valid_o | output | 1 | Link output byte valid |
| link_tx_ready_i | input | 1 | Neighbour accepts the byte |
| link_rx_data_i | input | 8 | Reply byte from the neighbour |
| link_rx_valid_i | input | 1 | Reply byte valid |
| link_rx_ready_o | output | 1 | Reader accepts a reply byte |
| up_data_o | output | 8 | Upstream byte (length, data or terminator) |
| up_valid_o | output | 1 | Upstream byte valid |
| up_ready_i | input | 1 | Upstream accepts the byte |

## Verification
A wrong byte index or address register shows up on the link output in the very transaction where it goes wrong. A misplaced address byte, a missed step or a carry outside the word size appears as a wrong address byte before any reply is requested. A buffer pointer or block counter that slips shows up later, at the next packet boundary. It appears as a length byte in place of data, or data in place of a length byte, or as a terminator arriving early or late against the 611-byte upstream stream. A lost or duplicated reply byte shifts every later data byte of the run. Word size is latched at the start, and a start accepted mid-run would change the address width. That fault becomes visible at the next peek command.

// File: rtl/peek_reader_pkg.sv
`timescale 1ns/1ps
package peek_reader_pkg;
   typedef enum logic [2:0] {
      PK_IDLE,
      PK_CMD,
      PK_ADDR,
      PK_DATA,
      PK_LEN,
      PK_SEND,
      PK_TERM
   } pk_state_t;
endpackage

// File: rtl/peek_addr_gen.sv
`timescale 1ns/1ps
module peek_addr_gen #(
   parameter int WIDE_BYTES   = 4,
   parameter int NARROW_BYTES = 2,
   localparam int AW    = 8 * WIDE_BYTES,
   localparam int IDX_W = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide_i,
   input  logic             init_i,
   input  logic             init_wide_i,
   input  logic             step_i,
   input  logic [IDX_W-1:0] sel_i,
   output logic [7:0]       byte_o
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] init_val;
   logic [AW-1:0] step_val;
   logic [AW-1:0] mask_val;
   logic [7:0]    lane [WIDE_BYTES];

   always_comb begin
      init_val = '0;
      if (init_wide_i) init_val[8*WIDE_BYTES-1] = 1'b1;
      else             init_val[8*NARROW_BYTES-1] = 1'b1;
   end

   always_comb begin
      step_val = wide_i ? AW'(WIDE_BYTES) : AW'(NARROW_BYTES);
      mask_val = wide_i ? {AW{1'b1}} : ((AW'(1) << (8*NARROW_BYTES)) - AW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (init_i) addr_q <= init_val;
      else if (step_i) addr_q <= (addr_q + step_val) & mask_val;
   end

   for (genvar g = 0; g < WIDE_BYTES; g++) begin : g_lane
      assign lane[g] = addr_q[8*g +: 8];
   end

   assign byte_o = lane[sel_i];
endmodule

// File: rtl/peek_buf.sv
`timescale 1ns/1ps
module peek_buf #(
   parameter int DEPTH = 60,
   localparam int PW = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       wr_i,
   input  logic [7:0] wr_data_i,
   input  logic       rd_adv_i,
   output logic [7:0] rd_data_o,
   output logic       wr_last_o,
   output logic       rd_last_o
);
   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (clr_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_i && wr_ptr != PW'(DEPTH)) wr_ptr <= wr_ptr + 1'b1;
         if (rd_adv_i && rd_ptr != PW'(DEPTH-1)) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_i && wr_ptr < PW'(DEPTH)) mem[wr_ptr] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_ptr];
   assign wr_last_o = (wr_ptr == PW'(DEPTH-1));
   assign rd_last_o = (rd_ptr == PW'(DEPTH-1));
endmodule

// File: rtl/peek_ctrl.sv
`timescale 1ns/1ps
module peek_ctrl
   import peek_reader_pkg::*;
#(
   parameter int WIDE_BYTES   = 4,
   parameter int NARROW_BYTES = 2,
   parameter int NUM_BLOCKS   = 10,
   localparam int IDX_W = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1,
   localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             word4_i,
   input  logic             tx_ready_i,
   input  logic             rx_valid_i,
   input  logic             up_ready_i,
   input  logic             buf_wr_last_i,
   input  logic             buf_rd_last_i,
   output pk_state_t        state_o,
   output logic             wide_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             addr_init_o,
   output logic             addr_step_o,
   output logic             buf_wr_o,
   output logic             buf_clr_o,
   output logic             buf_rd_adv_o
);
   pk_state_t        st_q;
   logic             wide_q;
   logic [IDX_W-1:0] idx_q;
   logic [BLK_W-1:0] blk_q;
   logic             idx_last;
   logic             blk_last;

   assign idx_last = (idx_q == (wide_q ? IDX_W'(WIDE_BYTES-1) : IDX_W'(NARROW_BYTES-1)));
   assign blk_last = (blk_q == BLK_W'(NUM_BLOCKS-1));

   always_comb begin
      addr_init_o  = (st_q == PK_IDLE) && start_i;
      addr_step_o  = (st_q == PK_DATA) && rx_valid_i && idx_last;
      buf_wr_o     = (st_q == PK_DATA) && rx_valid_i;
      buf_rd_adv_o = (st_q == PK_SEND) && up_ready_i;
      buf_clr_o    = addr_init_o || (buf_rd_adv_o && buf_rd_last_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PK_IDLE;
         wide_q <= 1'b0;
         idx_q  <= '0;
         blk_q  <= '0;
      end else begin
         unique case (st_q)
            PK_IDLE: if (start_i) begin
               wide_q <= word4_i;
               blk_q  <= '0;
               idx_q  <= '0;
               st_q   <= PK_CMD;
            end
            PK_CMD: if (tx_ready_i) begin
               idx_q <= '0;
               st_q  <= PK_ADDR;
            end
            PK_ADDR: if (tx_ready_i) begin
               if (idx_last) begin
                  idx_q <= '0;
                  st_q  <= PK_DATA;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PK_DATA: if (rx_valid_i) begin
               if (idx_last) begin
                  idx_q <= '0;
                  st_q  <= buf_wr_last_i ? PK_LEN : PK_CMD;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PK_LEN: if (up_ready_i) st_q <= PK_SEND;
            PK_SEND: if (up_ready_i && buf_rd_last_i) begin
               if (blk_last) begin
                  st_q <= PK_TERM;
               end else begin
                  blk_q <= blk_q + 1'b1;
                  st_q  <= PK_CMD;
               end
            end
            PK_TERM: if (up_ready_i) st_q <= PK_IDLE;
            default: st_q <= PK_IDLE;
         endcase
      end
   end

   assign state_o = st_q;
   assign wide_o  = wide_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/link_peek_reader.sv
`timescale 1ns/1ps
module link_peek_reader
   import peek_reader_pkg::*;
#(
   parameter int         WIDE_BYTES   = 4,
   parameter int         NARROW_BYTES = 2,
   parameter int         BLOCK_BYTES  = 60,
   parameter int         NUM_BLOCKS   = 10,
   parameter logic [7:0] PEEK_CODE    = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       word4_i,
   output logic       busy_o,
   output logic [7:0] link_tx_data_o,
   output logic       link_tx_valid_o,
   input  logic       link_tx_ready_i,
   input  logic [7:0] link_rx_data_i,
   input  logic       link_rx_valid_i,
   output logic       link_rx_ready_o,
   output logic [7:0] up_data_o,
   output logic       up_valid_o,
   input  logic       up_ready_i
);
   localparam int IDX_W = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1;

   if (BLOCK_BYTES < 1 || BLOCK_BYTES > 255) begin : g_bad_block
      $error("BLOCK_BYTES must fit a nonzero length byte");
   end
   if (NARROW_BYTES < 1 || NARROW_BYTES >= WIDE_BYTES) begin : g_bad_narrow
      $error("NARROW_BYTES must be positive and below WIDE_BYTES");
   end
   if ((BLOCK_BYTES % WIDE_BYTES) != 0 || (BLOCK_BYTES % NARROW_BYTES) != 0) begin : g_bad_align
      $error("BLOCK_BYTES must hold a whole number of words of either size");
   end
   if (NUM_BLOCKS < 1) begin : g_bad_count
      $error("NUM_BLOCKS must be at least one");
   end

   pk_state_t        state;
   logic             wide;
   logic [IDX_W-1:0] idx;
   logic             addr_init;
   logic             addr_step;
   logic             buf_wr;
   logic             buf_clr;
   logic             buf_rd_adv;
   logic             buf_wr_last;
   logic             buf_rd_last;
   logic [7:0]       addr_byte;
   logic [7:0]       buf_byte;

   peek_ctrl #(
      .WIDE_BYTES  (WIDE_BYTES),
      .NARROW_BYTES(NARROW_BYTES),
      .NUM_BLOCKS  (NUM_BLOCKS)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .word4_i      (word4_i),
      .tx_ready_i   (link_tx_ready_i),
      .rx_valid_i   (link_rx_valid_i),
      .up_ready_i   (up_ready_i),
      .buf_wr_last_i(buf_wr_last),
      .buf_rd_last_i(buf_rd_last),
      .state_o      (state),
      .wide_o       (wide),
      .idx_o        (idx),
      .addr_init_o  (addr_init),
      .addr_step_o  (addr_step),
      .buf_wr_o     (buf_wr),
      .buf_clr_o    (buf_clr),
      .buf_rd_adv_o (buf_rd_adv)
   );

   peek_addr_gen #(
      .WIDE_BYTES  (WIDE_BYTES),
      .NARROW_BYTES(NARROW_BYTES)
   ) addr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wide_i     (wide),
      .init_i     (addr_init),
      .init_wide_i(word4_i),
      .step_i     (addr_step),
      .sel_i      (idx),
      .byte_o     (addr_byte)
   );

   peek_buf #(
      .DEPTH(BLOCK_BYTES)
   ) buf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (buf_clr),
      .wr_i     (buf_wr),
      .wr_data_i(link_rx_data_i),
      .rd_adv_i (buf_rd_adv),
      .rd_data_o(buf_byte),
      .wr_last_o(buf_wr_last),
      .rd_last_o(buf_rd_last)
   );

   always_comb begin
      busy_o          = (state != PK_IDLE);
      link_tx_valid_o = (state == PK_CMD) || (state == PK_ADDR);
      link_tx_data_o  = (state == PK_CMD) ? PEEK_CODE : addr_byte;
      link_rx_ready_o = (state == PK_DATA);
      up_valid_o      = (state == PK_LEN) || (state == PK_SEND) || (state == PK_TERM);
      unique case (state)
         PK_LEN:  up_data_o = 8'(BLOCK_BYTES);
         PK_SEND: up_data_o = buf_byte;
         default: up_data_o = 8'h00;
      endcase
   end
endmodule

// File: rtl/link_peek_reader_chk.sv
`timescale 1ns/1ps
module link_peek_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic [7:0] link_tx_data_o,
   input logic       link_tx_valid_o,
   input logic       link_tx_ready_i,
   input logic       link_rx_ready_o,
   input logic [7:0] up_data_o,
   input logic       up_valid_o,
   input logic       up_ready_i
);
   assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      link_tx_valid_o && !link_tx_ready_i |=> link_tx_valid_o && $stable(link_tx_data_o));

   assert_up_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid_o && !up_ready_i |=> up_valid_o && $stable(up_data_o));

   assert_one_stream_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({link_tx_valid_o, link_rx_ready_o, up_valid_o}) <= 1);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !link_tx_valid_o && !link_rx_ready_o && !up_valid_o);

   assert_busy_ends_on_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(up_valid_o && up_ready_i && up_data_o == 8'h00));
endmodule

bind link_peek_reader link_peek_reader_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy_o         (busy_o),
   .link_tx_data_o (link_tx_data_o),
   .link_tx_valid_o(link_tx_valid_o),
   .link_tx_ready_i(link_tx_ready_i),
   .link_rx_ready_o(link_rx_ready_o),
   .up_data_o      (up_data_o),
   .up_valid_o     (up_valid_o),
   .up_ready_i     (up_ready_i)
);

// File: tb/link_peek_reader_tb_top.sv
`timescale 1ns/1ps
module link_peek_reader_tb_top;
   localparam int BLK  = 60;
   localparam int NBLK = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       word4_i = 1'b0;
   logic       busy_o;
   logic [7:0] link_tx_data_o;
   logic       link_tx_valid_o;
   logic       link_tx_ready_i = 1'b0;
   logic [7:0] link_rx_data_i = 8'h00;
   logic       link_rx_valid_i = 1'b0;
   logic       link_rx_ready_o;
   logic [7:0] up_data_o;
   logic       up_valid_o;
   logic       up_ready_i = 1'b0;

   always #2.5 clk = ~clk;

   link_peek_reader dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .word4_i        (word4_i),
      .busy_o         (busy_o),
      .link_tx_data_o (link_tx_data_o),
      .link_tx_valid_o(link_tx_valid_o),
      .link_tx_ready_i(link_tx_ready_i),
      .link_rx_data_i (link_rx_data_i),
      .link_rx_valid_i(link_rx_valid_i),
      .link_rx_ready_o(link_rx_ready_o),
      .up_data_o      (up_data_o),
      .up_valid_o     (up_valid_o),
      .up_ready_i     (up_ready_i)
   );

   int         n_vec = 0;
   int         n_bad = 0;
   logic [7:0] exp_q[$];
   logic [7:0] reply_q[$];
   int         ws = 4;
   int         nb_pos = 0;
   int         nb_count = 0;
   logic [31:0] nb_addr = 0;
   logic [31:0] nb_exp = 0;
   logic       rx_taken = 1'b0;
   logic       term_seen = 1'b0;
   logic       sb_on = 1'b0;

   function automatic logic [7:0] mem_byte(logic [31:0] a, int i);
      return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'(i * 8'h35 + 8'h11);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // neighbour model and upstream scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && sb_on) begin
         if (term_seen) begin
            check("R8 busy low after terminator", {31'b0, busy_o}, 32'd0);
            term_seen = 1'b0;
         end
         if (rx_taken) begin
            link_rx_valid_i = 1'b0;
            rx_taken = 1'b0;
         end
         link_tx_ready_i = ($urandom_range(0, 3) != 0);
         up_ready_i      = ($urandom_range(0, 2) != 0);
         if (!link_rx_valid_i && reply_q.size() > 0 && $urandom_range(0, 3) != 0) begin
            link_rx_valid_i = 1'b1;
            link_rx_data_i  = reply_q[0];
         end
         // link output handshake completes at the coming edge
         if (link_tx_valid_o && link_tx_ready_i) begin
            if (nb_pos == 0) begin
               check("R2 peek command byte", {24'b0, link_tx_data_o}, 32'h1);
            end else begin
               nb_addr = nb_addr | ({24'b0, link_tx_data_o} << (8 * (nb_pos - 1)));
            end
            nb_pos++;
            if (nb_pos == ws + 1) begin
               if (nb_count == 0) check("R4 first address", nb_addr, nb_exp);
               else               check("R5 address step R3 width", nb_addr, nb_exp);
               for (int i = 0; i < ws; i++) reply_q.push_back(mem_byte(nb_addr, i));
               nb_exp   = nb_exp + 32'(ws);
               nb_addr  = 0;
               nb_pos   = 0;
               nb_count++;
            end
         end
         if (link_rx_valid_i && link_rx_ready_o) begin
            void'(reply_q.pop_front());
            rx_taken = 1'b1;
         end
         if (up_valid_o && up_ready_i) begin
            if (exp_q.size() == 0) begin
               check("R7 unexpected upstream byte", {24'b0, up_data_o}, 32'hFFFF);
            end else begin
               check("R6 R7 upstream stream", {24'b0, up_data_o}, {24'b0, exp_q.pop_front()});
               if (exp_q.size() == 0) begin
                  check("R8 busy during terminator", {31'b0, busy_o}, 32'd1);
                  term_seen = 1'b1;
               end
            end
         end
      end
   end

   task automatic run(input logic wide, input logic poke);
      ws = wide ? 4 : 2;
      nb_exp   = wide ? 32'h8000_0000 : 32'h0000_8000;
      nb_count = 0;
      nb_pos   = 0;
      nb_addr  = 0;
      for (int b = 0; b < NBLK; b++) begin
         exp_q.push_back(8'(BLK));
         for (int t = 0; t < BLK / ws; t++) begin
            logic [31:0] a;
            a = nb_exp + 32'((b * (BLK / ws) + t) * ws);
            for (int i = 0; i < ws; i++) exp_q.push_back(mem_byte(a, i));
         end
      end
      exp_q.push_back(8'h00);
      @(negedge clk);
      start_i = 1'b1;
      word4_i = wide;
      @(negedge clk);
      start_i = 1'b0;
      check("R1 busy after start", {31'b0, busy_o}, 32'd1);
      if (poke) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1;
         word4_i = ~wide;
         @(negedge clk);
         start_i = 1'b0;
         check("R9 start ignored while busy", {31'b0, busy_o}, 32'd1);
      end
      while (busy_o || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check("R7 all upstream bytes seen", exp_q.size(), 0);
      check("R2 no extra reply bytes", reply_q.size(), 0);
      check("R7 peek count", nb_count, (NBLK * BLK) / ws);
      check("R1 idle after run", {31'b0, busy_o}, 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 busy reset", {31'b0, busy_o}, 32'd0);
      check("R11 tx valid reset", {31'b0, link_tx_valid_o}, 32'd0);
      check("R11 rx ready reset", {31'b0, link_rx_ready_o}, 32'd0);
      check("R11 up valid reset", {31'b0, up_valid_o}, 32'd0);
      sb_on = 1'b1;
      run(1'b1, 1'b1);
      run(1'b0, 1'b1);
      run(1'b1, 1'b0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule